// File: doc/BRIEF.md
# Per-Core Memory Bandwidth Regulator

This block limits how many memory accesses each core of a multicore cluster may issue within a fixed regulation period. Each core has one event input that pulses once per memory access (standing in for a performance-counter increment) and one throttle output that tells the core's scheduler to hold back further memory traffic. Software assigns every core a per-period budget and marks each core as either soft or hard. The accepted budgets together can never exceed a guaranteed memory rate, which is a parameter.

At every period boundary, a soft core's allowance is set to what it actually used in the period just ended, capped at its budget. The unused remainder of the budget goes into a shared reclaim pool. When a soft core runs out, it asks the pool for more. The pool hands out fixed-size chunks, one grant per cycle, and the lowest-numbered requester wins. A hard core keeps its full budget and never touches the pool. When no core can make further progress, all throttles lift until the period ends. The pool is rebuilt from scratch at every boundary.

Top module: `mem_bw_regulator`

## Requirements
- R1: After reset every throttle is low, the pool is empty, and each core may make DEF_BUDGET (default 16) accesses in the first period.
- R2: A budget write (core index, budget, hard flag) is accepted only if the sum of all configured budgets, with the written core's old budget replaced by the new one, stays at or below GUAR_RATE (default 96). Otherwise the write is ignored. Accepted values take effect at the next period boundary.
- R3: Every access pulse increments the core's used count. A core's throttle goes high in the cycle right after the access that brings its used count up to its available allowance. It stays high until a grant, free-run, or a period boundary.
- R4: At a period boundary, a soft core's allowance becomes min(usage in the ending period, budget). The pool is reloaded with the sum of the soft cores' budget minus allowance, and any leftover pool content is discarded.
- R5: A soft core at its limit requests the pool. The lowest-indexed requester receives min(CHUNK, pool) extra units at the next edge (CHUNK defaults to 4), and its throttle drops in the following cycle. Only one grant is made per cycle, and no grant is made in the last cycle of a period.
- R6: Once every core is at its limit and cannot be refilled (it is hard, or the pool is empty), all throttles drop from the next cycle until the period ends.
- R7: A hard core starts each period with its full budget, donates nothing, and never receives a grant, even while the pool is non-empty.
- R8: A period lasts PERIOD_LEN cycles (default 64). At its last edge, every used count clears and the free-run state ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessEvt | input | NUM_CORES | One pulse per memory access, one bit per core |
| cfgWrEn | input | 1 | Budget register write strobe |
| cfgWrCore | input | $clog2(NUM_CORES) | Index of the core being configured |
| cfgWrBudget | input | CNT_W | Accesses allowed per period |
| cfgWrHard | input | 1 | 1 = hard reservation, 0 = soft |
| throttle | output | NUM_CORES | High: the core must stop issuing memory accesses |

## Verification
Two functions can land on the same edge. The first case is a pool grant and a fresh access to the same core. The bench provokes it by keeping a core issuing accesses every cycle while it crosses its allowance. It then expects the throttle to be high for exactly one cycle and clear on the next, because the grant outruns the single extra count. The second case is several cores reaching their limit together at a period start, when their predicted allowance is zero. There the bench expects the throttles to clear one per cycle in ascending core order. Period boundaries that coincide with free-run are judged by sampling throttle on both sides of the last edge.

// File: rtl/bwreg_pkg.sv
package bwreg_pkg;

  // Widest core index carried by the control strobes (up to 16 cores).
  localparam int MAX_IDX_W = 4;

  typedef struct packed {
    logic                 periodEnd;   // last cycle of the regulation period
    logic                 freeRun;     // every core exhausted: throttles lifted
    logic                 grantValid;  // hand a pool chunk to grantIdx this edge
    logic [MAX_IDX_W-1:0] grantIdx;
  } bwregStrb_t;

endpackage

// File: rtl/bwreg_core_slice.sv
module bwreg_core_slice #(
  parameter int SUM_W       = 8,
  parameter int RESET_AVAIL = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessIn,
  input  logic             periodEnd,
  input  logic             freeRun,
  input  logic             grantHere,
  input  logic             poolEmpty,
  input  logic             cfgHard,
  input  logic [SUM_W-1:0] grantAmt,
  input  logic [SUM_W-1:0] cfgBudget,
  output logic             throttle,
  output logic             req,
  output logic             exhausted,
  output logic [SUM_W-1:0] donate
);

  logic [SUM_W-1:0] usedCnt;
  logic [SUM_W-1:0] availCnt;
  logic             hardAct;
  logic [SUM_W-1:0] usedNext;
  logic [SUM_W-1:0] predUse;
  logic             atLimit;

  // Saturating usage count including the access of this cycle.
  always_comb begin
    usedNext = usedCnt;
    if (accessIn && (usedCnt != {SUM_W{1'b1}})) usedNext = usedCnt + 1'b1;
  end

  // Prediction for the next period: this period's usage, capped at the budget.
  always_comb begin
    predUse = (usedNext < cfgBudget) ? usedNext : cfgBudget;
    donate  = cfgHard ? '0 : (cfgBudget - predUse);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedCnt  <= '0;
      availCnt <= SUM_W'(RESET_AVAIL);
      hardAct  <= 1'b0;
    end else if (periodEnd) begin
      usedCnt  <= '0;
      availCnt <= cfgHard ? cfgBudget : predUse;
      hardAct  <= cfgHard;
    end else begin
      usedCnt <= usedNext;
      if (grantHere) availCnt <= availCnt + grantAmt;
    end
  end

  assign atLimit   = (usedCnt >= availCnt);
  assign throttle  = atLimit & ~freeRun;
  assign req       = atLimit & ~hardAct;
  assign exhausted = atLimit & (hardAct | poolEmpty);

  AST_THROTTLE_ONSET: assert property (@(posedge clk) disable iff (!rstN)
    (!periodEnd && !freeRun && !grantHere && accessIn &&
     (({1'b0, usedCnt} + 1'b1) == {1'b0, availCnt})) |=> throttle); // R3

  AST_HARD_FIXED_ALLOWANCE: assert property (@(posedge clk) disable iff (!rstN)
    (hardAct && !periodEnd) |=> (availCnt == $past(availCnt))); // R7

  AST_USED_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (usedCnt == '0)); // R8

endmodule

// File: rtl/bwreg_datapath.sv
module bwreg_datapath #(
  parameter int NUM_CORES  = 4,
  parameter int CNT_W      = 8,
  parameter int SUM_W      = 8,
  parameter int CHUNK      = 4,
  parameter int GUAR_RATE  = 96,
  parameter int DEF_BUDGET = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         accessEvt,
  input  logic                         cfgWrEn,
  input  logic [$clog2(NUM_CORES)-1:0] cfgWrCore,
  input  logic [CNT_W-1:0]             cfgWrBudget,
  input  logic                         cfgWrHard,
  input  bwreg_pkg::bwregStrb_t        strb,
  output logic [NUM_CORES-1:0]         throttle,
  output logic [NUM_CORES-1:0]         reqVec,
  output logic                         poolNonZero,
  output logic                         allExhausted
);

  localparam int ACC_W = CNT_W + $clog2(NUM_CORES) + 1;

  logic [CNT_W-1:0]            budgetReg [NUM_CORES];
  logic [NUM_CORES-1:0]        hardReg;
  logic [SUM_W-1:0]            pool;
  logic [SUM_W-1:0]            grantAmt;
  logic [SUM_W-1:0]            donateSum;
  logic [ACC_W-1:0]            budgetSum;
  logic [ACC_W-1:0]            candSum;
  logic                        wrAccept;
  logic [NUM_CORES-1:0]        grantHere;
  logic [NUM_CORES-1:0]        exhaustedVec;
  logic [NUM_CORES-1:0][SUM_W-1:0] donateVec;

  // Admission check on budget writes: the configured total must fit the guaranteed rate.
  always_comb begin
    budgetSum = '0;
    for (int i = 0; i < NUM_CORES; i++) budgetSum = budgetSum + ACC_W'(budgetReg[i]);
    candSum  = budgetSum - ACC_W'(budgetReg[cfgWrCore]) + ACC_W'(cfgWrBudget);
    wrAccept = cfgWrEn && (int'(cfgWrCore) < NUM_CORES) && (candSum <= ACC_W'(GUAR_RATE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CORES; i++) budgetReg[i] <= CNT_W'(DEF_BUDGET);
      hardReg <= '0;
    end else if (wrAccept) begin
      budgetReg[cfgWrCore] <= cfgWrBudget;
      hardReg[cfgWrCore]   <= cfgWrHard;
    end
  end

  // Reclaim pool: rebuilt from donations each boundary, drained chunk by chunk.
  assign grantAmt    = (pool < SUM_W'(CHUNK)) ? pool : SUM_W'(CHUNK);
  assign poolNonZero = (pool != '0);

  always_comb begin
    donateSum = '0;
    for (int i = 0; i < NUM_CORES; i++) donateSum = donateSum + donateVec[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pool <= '0;
    else if (strb.periodEnd)  pool <= donateSum;
    else if (strb.grantValid) pool <= pool - grantAmt;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    assign grantHere[g] = strb.grantValid && (strb.grantIdx == bwreg_pkg::MAX_IDX_W'(g));

    bwreg_core_slice #(
      .SUM_W       (SUM_W),
      .RESET_AVAIL (DEF_BUDGET)
    ) u_slice (
      .clk       (clk),
      .rstN      (rstN),
      .accessIn  (accessEvt[g]),
      .periodEnd (strb.periodEnd),
      .freeRun   (strb.freeRun),
      .grantHere (grantHere[g]),
      .poolEmpty (~poolNonZero),
      .cfgHard   (hardReg[g]),
      .grantAmt  (grantAmt),
      .cfgBudget (SUM_W'(budgetReg[g])),
      .throttle  (throttle[g]),
      .req       (reqVec[g]),
      .exhausted (exhaustedVec[g]),
      .donate    (donateVec[g])
    );
  end

  assign allExhausted = &exhaustedVec;

  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rstN)
    budgetSum <= ACC_W'(GUAR_RATE)); // R2

  AST_POOL_NO_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodEnd |=> (pool <= $past(pool))); // R4

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantValid |-> (|(reqVec & grantHere))); // R5

endmodule

// File: rtl/bwreg_ctrl.sv
module bwreg_ctrl #(
  parameter int NUM_CORES  = 4,
  parameter int PERIOD_LEN = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CORES-1:0]  reqVec,
  input  logic                  poolNonZero,
  input  logic                  allExhausted,
  output bwreg_pkg::bwregStrb_t strb
);

  localparam int PCNT_W = $clog2(PERIOD_LEN);

  logic [PCNT_W-1:0]                periodCnt;
  logic                             periodEnd;
  logic                             freeRun;
  logic [bwreg_pkg::MAX_IDX_W-1:0]  pickIdx;

  assign periodEnd = (periodCnt == PCNT_W'(PERIOD_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN)          periodCnt <= '0;
    else if (periodEnd) periodCnt <= '0;
    else                periodCnt <= periodCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             freeRun <= 1'b0;
    else if (periodEnd)    freeRun <= 1'b0;
    else if (allExhausted) freeRun <= 1'b1;
  end

  // Fixed priority: the lowest-numbered requesting core wins the chunk.
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--)
      if (reqVec[i]) pickIdx = bwreg_pkg::MAX_IDX_W'(i);
  end

  always_comb begin
    strb.periodEnd  = periodEnd;
    strb.freeRun    = freeRun;
    strb.grantValid = (|reqVec) && poolNonZero && !periodEnd && !freeRun;
    strb.grantIdx   = pickIdx;
  end

  AST_FREE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (freeRun && !periodEnd) |=> freeRun); // R6

  AST_FREE_ENDS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> !freeRun); // R6

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (periodCnt == '0)); // R8

endmodule

// File: rtl/mem_bw_regulator.sv
module mem_bw_regulator #(
  parameter int NUM_CORES  = 4,
  parameter int CNT_W      = 8,
  parameter int PERIOD_LEN = 64,
  parameter int CHUNK      = 4,
  parameter int GUAR_RATE  = 96,
  parameter int DEF_BUDGET = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         accessEvt,
  input  logic                         cfgWrEn,
  input  logic [$clog2(NUM_CORES)-1:0] cfgWrCore,
  input  logic [CNT_W-1:0]             cfgWrBudget,
  input  logic                         cfgWrHard,
  output logic [NUM_CORES-1:0]         throttle
);

  // Allowances and pool never exceed GUAR_RATE; one spare bit keeps saturation clear of it.
  localparam int SUM_W = $clog2(GUAR_RATE + 1) + 1;

  bwreg_pkg::bwregStrb_t strb;
  logic [NUM_CORES-1:0]  reqVec;
  logic                  poolNonZero;
  logic                  allExhausted;

  bwreg_ctrl #(
    .NUM_CORES  (NUM_CORES),
    .PERIOD_LEN (PERIOD_LEN)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqVec       (reqVec),
    .poolNonZero  (poolNonZero),
    .allExhausted (allExhausted),
    .strb         (strb)
  );

  bwreg_datapath #(
    .NUM_CORES  (NUM_CORES),
    .CNT_W      (CNT_W),
    .SUM_W      (SUM_W),
    .CHUNK      (CHUNK),
    .GUAR_RATE  (GUAR_RATE),
    .DEF_BUDGET (DEF_BUDGET)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .accessEvt    (accessEvt),
    .cfgWrEn      (cfgWrEn),
    .cfgWrCore    (cfgWrCore),
    .cfgWrBudget  (cfgWrBudget),
    .cfgWrHard    (cfgWrHard),
    .strb         (strb),
    .throttle     (throttle),
    .reqVec       (reqVec),
    .poolNonZero  (poolNonZero),
    .allExhausted (allExhausted)
  );

endmodule

// File: tb/mem_bw_regulator_tb.sv
`timescale 1ns/1ps
module mem_bw_regulator_tb;

  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NC-1:0] accessEvt;
  logic          cfgWrEn;
  logic [1:0]    cfgWrCore;
  logic [7:0]    cfgWrBudget;
  logic          cfgWrHard;
  logic [NC-1:0] throttle;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #4 clk = ~clk;  // 8 ns period

  mem_bw_regulator #(
    .NUM_CORES (NC), .CNT_W (8), .PERIOD_LEN (64),
    .CHUNK (4), .GUAR_RATE (96), .DEF_BUDGET (16)
  ) u_dut (
    .clk (clk), .rstN (rstN), .accessEvt (accessEvt),
    .cfgWrEn (cfgWrEn), .cfgWrCore (cfgWrCore), .cfgWrBudget (cfgWrBudget),
    .cfgWrHard (cfgWrHard), .throttle (throttle)
  );

  task automatic chk(input string req, input logic [NC-1:0] got, input logic [NC-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: throttle actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic chkBit(input string req, input int core, input logic exp);
    checks++;
    if (throttle[core] !== exp) begin
      fails++;
      $display("FAIL %s: throttle[%0d] actual %b expected %b", req, core, throttle[core], exp);
    end
  endtask

  // Access pattern for the edge numbered n (edges counted from reset release).
  function automatic logic [NC-1:0] accFor(input int n);
    logic [NC-1:0] a = '0;
    a[0] = (n >= 1 && n <= 16) || (n >= 68 && n <= 87) || (n >= 163 && n <= 186);
    a[1] = (n >= 163 && n <= 186) || (n >= 193 && n <= 216);
    a[2] = (n >= 131 && n <= 186) || (n >= 193 && n <= 208);
    a[3] = (n >= 131 && n <= 146);
    return a;
  endfunction

  initial begin
    rstN = 1'b0; accessEvt = '0;
    cfgWrEn = 1'b0; cfgWrCore = '0; cfgWrBudget = '0; cfgWrHard = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset", throttle, 4'b0000);

    for (int n = 1; n <= 220; n++) begin
      accessEvt = accFor(n);
      cfgWrEn = 1'b0;
      if (n == 100) begin cfgWrEn = 1'b1; cfgWrCore = 2'd3; cfgWrBudget = 8'd16; cfgWrHard = 1'b1; end
      if (n == 101) begin cfgWrEn = 1'b1; cfgWrCore = 2'd2; cfgWrBudget = 8'd60; cfgWrHard = 1'b0; end // rejected: 108 > 96
      if (n == 102) begin cfgWrEn = 1'b1; cfgWrCore = 2'd1; cfgWrBudget = 8'd40; cfgWrHard = 1'b0; end // accepted: 88
      @(negedge clk);
      // Outputs now reflect state after edge n.
      if (n <= 16) chkBit("R1 R3 fill sweep", 0, (n == 16));
      case (n)
        40:  chk("R3 hold throttle", throttle, 4'b0001);
        63:  chk("R3 hold to period end", throttle, 4'b0001);
        64:  chk("R8 R4 boundary reload", throttle, 4'b1110);
        65:  chk("R5 grant core1 first", throttle, 4'b1100);
        66:  chk("R5 grant core2 next", throttle, 4'b1000);
        67:  chk("R5 grant core3 last", throttle, 4'b0000);
        82:  chkBit("R3 below limit", 0, 1'b0);
        83:  chkBit("R3 onset", 0, 1'b1);
        84:  chkBit("R5 grant with access", 0, 1'b0);
        87:  chkBit("R3 second onset", 0, 1'b1);
        88:  chkBit("R5 second grant", 0, 1'b0);
        128: chk("R4 R7 prediction at boundary", throttle, 4'b0110);
        129: chk("R5 priority core1", throttle, 4'b0100);
        130: chk("R5 priority core2", throttle, 4'b0000);
        145: chkBit("R7 hard below budget", 3, 1'b0);
        146: chkBit("R7 hard at budget", 3, 1'b1);
        155: chkBit("R7 hard gets no grant", 3, 1'b1);
        188: chk("R6 free run", throttle, 4'b0000);
        191: chk("R6 free run to period end", throttle, 4'b0000);
        192: chk("R8 new period start", throttle, 4'b0000);
        207: chkBit("R2 rejected budget below", 2, 1'b0);
        208: chkBit("R2 rejected budget kept at 16", 2, 1'b1);
        209: chkBit("R5 grant after reject test", 2, 1'b0);
        215: chkBit("R4 predicted 24 below", 1, 1'b0);
        216: chkBit("R4 predicted 24 reached", 1, 1'b1);
        217: chkBit("R5 refill core1", 1, 1'b0);
        default: ;
      endcase
    end
    accessEvt = '0;
    cfgWrEn = 1'b0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule